// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single timer channel for a larger timer unit. An up-counter advances on a count clock. That count clock comes from an external base tick, divided by a factor chosen in the control register. When the counter equals the compare value, the channel raises a match flag. In periodic mode it also returns the counter to zero on the following count tick, so one period lasts compare value + 1 count ticks. A separate overflow flag records every advance out of the all-ones value.

Software reaches three 32-bit registers through a simple register port with byte addresses: control/status at 0x0, counter at 0x4 and compare at 0x8. The two flags are cleared by writing zero to them. Writing one to a flag leaves it unchanged. A counter write does not act at once: it lands on the second count tick after the write, as it would when the counter lives in a slow clock domain. A start/stop register outside the channel gates the counting. The match flag, qualified by an enable bit and a request-type field, drives either an interrupt line or a level DMA request line.

Top module: `cmt_channel`

## Requirements
- R1: Reset clears all registers. The register at byte offset 0x0 is control/status, 0x4 is the counter and 0x8 is compare. The word is chosen by address bits 3:2, and offset 0xC reads as 0.
- R2: The control register stores these writable fields: bit 9 compare mode, bit 8 periodic, bit 7 request enable, bits 5:4 request type, bit 3 debug-hold and bits 2:0 clock select. Bit 15 is the match flag and bit 14 is the overflow flag. All other bits read as 0.
- R3: Clock select 7 counts every base tick, 4 every 8th, 5 every 32nd and 6 every 128th. Values 0 to 3 stop the count clock. Any write to the control register restarts the divider phase.
- R4: While start_i is low, the counter holds its value.
- R5: In periodic mode (bit 8 = 1), a count tick taken while the counter equals compare sets the match flag and loads 0. The period is therefore compare + 1 ticks.
- R6: With bit 8 = 0, a count tick taken at the compare value sets the match flag, and the counter keeps incrementing past it.
- R7: A count tick that advances the counter out of all-ones sets the overflow flag. In periodic mode with compare = all-ones, both flags set on that tick.
- R8: Writing 0 to bit 15 or bit 14 clears that flag, and writing 1 leaves it as it is. If a flag is set by hardware in the same cycle that software clears it, the set wins.
- R9: A counter write takes effect on the second count tick after the write, whatever the level of start_i. Until then, reads return the old value. A newer counter write restarts the wait.
- R10: irq_o is the match flag AND bit 7 AND (request type = 2). dma_req_o is the match flag AND bit 7 AND (request type = 1). Request types 0 and 3 drive neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Byte address of the register access |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| start_i | input | 1 | Run enable from the shared start/stop register |
| tick_i | input | 1 | Base tick enable that feeds the divider |
| irq_o | output | 1 | Interrupt request (level) |
| dma_req_o | output | 1 | DMA request (level) |

## Verification
The embedded assertions check the following on every cycle:
- The counter holds while stopped.
- A periodic match returns the counter to zero.
- Divided count ticks are never back to back.
- A pending counter write never lands on the cycle after it was made.
- Hardware flag sets win over clears, and a written one keeps a flag.
- The two request outputs are never high together.

Some behaviour only the bench scenarios can show:
- The actual divide ratios and the dead clock-select codes.
- The exact period for each compare value.
- The two-tick latency of counter writes, including under a divided clock.
- The overflow-versus-match split at the all-ones boundary.
- The full request-type decode.

// File: rtl/cmt_pkg.sv
// Package: shared field positions, encodings and helpers for the
// compare-match timer channel. Assumes a 16-bit control field inside a
// 32-bit register word.
package cmt_pkg;

    localparam int DATA_W   = 32;
    localparam int PS_W     = 7;   // divider phase width, covers /128
    localparam int WORD_LSB = 2;   // byte address -> word index shift

    // control/status bit positions
    localparam int B_MATCH    = 15;
    localparam int B_OVF      = 14;
    localparam int B_CMPMODE  = 9;
    localparam int B_PERIODIC = 8;
    localparam int B_REQ_EN   = 7;
    localparam int B_REQ_LO   = 4;
    localparam int B_DBG_HOLD = 3;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DMA  = 2'd1,
        REQ_IRQ  = 2'd2,
        REQ_RSVD = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        W_CTRL    = 2'd0,
        W_COUNT   = 2'd1,
        W_COMPARE = 2'd2,
        W_NONE    = 2'd3
    } word_sel_t;

    localparam logic [2:0] SEL_DIV8   = 3'd4;
    localparam logic [2:0] SEL_DIV32  = 3'd5;
    localparam logic [2:0] SEL_DIV128 = 3'd6;
    localparam logic [2:0] SEL_DIV1   = 3'd7;

    // Divider terminal phase for a clock select code (ratio - 1).
    function automatic logic [PS_W-1:0] sel_limit(input logic [2:0] sel);
        case (sel)
            SEL_DIV8:   sel_limit = PS_W'(7);
            SEL_DIV32:  sel_limit = PS_W'(31);
            SEL_DIV128: sel_limit = PS_W'(127);
            default:    sel_limit = '0;
        endcase
    endfunction

    // Only the upper half of the select space drives a count clock.
    function automatic logic sel_valid(input logic [2:0] sel);
        sel_valid = sel[2];
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
// Prescaler: turns the base tick enable into a count-clock enable at the
// selected ratio. Assumes tick_i is a one-cycle enable in the clk domain.
// Restart realigns the phase to zero (used on control writes).
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [2:0] sel,
    input  logic       restart,
    output logic       cnt_en
);
    logic [PS_W-1:0] phase_q;
    logic [PS_W-1:0] limit;
    logic            sel_ok;

    // Purpose: decode the select code into a terminal phase.
    always_comb begin
        limit  = sel_limit(sel);
        sel_ok = sel_valid(sel);
    end

    assign cnt_en = tick_i && sel_ok && (phase_q == limit);

    // Purpose: advance the divider phase on each base tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (tick_i && sel_ok)
            phase_q <= (phase_q == limit) ? '0 : phase_q + 1'b1;
    end

    // R3: any divided ratio leaves at least one idle cycle between ticks
    assert_div_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && sel != SEL_DIV1 && !restart) |=> !cnt_en);

endmodule

// File: rtl/cmt_cnt_sync.sv
// Counter write synchroniser: holds a written counter value and releases
// it as a load on the SYNC_TICKS-th count tick after the write. Assumes
// the newest write replaces any pending one and restarts the wait.
module cmt_cnt_sync #(
    parameter int W          = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         cnt_en,
    output logic         load,
    output logic [W-1:0] load_val
);
    localparam int STG_W = $clog2(SYNC_TICKS + 1);

    logic             pend_q;
    logic [STG_W-1:0] stage_q;
    logic [W-1:0]     val_q;

    assign load     = pend_q && cnt_en && !wr && (stage_q == STG_W'(SYNC_TICKS - 1));
    assign load_val = val_q;

    // Purpose: capture writes and count count-ticks until release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            stage_q <= '0;
            val_q   <= '0;
        end else if (wr) begin
            pend_q  <= 1'b1;
            stage_q <= '0;
            val_q   <= wdata;
        end else if (pend_q && cnt_en) begin
            if (stage_q == STG_W'(SYNC_TICKS - 1))
                pend_q <= 1'b0;
            else
                stage_q <= stage_q + 1'b1;
        end
    end

    // R9: a load is a single pulse
    assert_single_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    generate
        if (SYNC_TICKS > 1) begin : g_latency_chk
            // R9: never lands on the cycle right after a write
            assert_no_early_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
                wr |=> !load);
        end
    endgenerate

endmodule

// File: rtl/cmt_counter.sv
// Counter core: up-counter with compare detection, periodic clear and
// wrap detection. Assumes a pending load has priority over counting and
// suppresses flag events on its tick.
module cmt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         run,
    input  logic         periodic,
    input  logic [W-1:0] cmp,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         hit,
    output logic         wrap
);
    logic step;
    logic at_cmp;
    logic at_max;

    // Purpose: derive this cycle's advance and event strobes.
    always_comb begin
        step   = cnt_en && run && !load;
        at_cmp = (count == cmp);
        at_max = &count;
        hit    = step && at_cmp;
        wrap   = step && at_max;
    end

    // Purpose: load, clear on periodic match, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (step)
            count <= (periodic && at_cmp) ? '0 : count + 1'b1;
    end

    // R4: stopped and no pending load means the value holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));

    // R5: periodic match returns to zero
    assert_periodic_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && run && !load && periodic && count == cmp) |=> (count == '0));

endmodule

// File: rtl/cmt_ctrl_reg.sv
// Control/status register: stores mode fields, keeps write-zero-to-clear
// match and overflow flags, and decodes the request outputs. Assumes a
// hardware set in the same cycle as a software clear wins.
module cmt_ctrl_reg
    import cmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic              wrap,
    output logic [DATA_W-1:0] rdata,
    output logic              periodic,
    output logic [2:0]        sel,
    output logic              match_flag,
    output logic              irq,
    output logic              dma_req
);
    logic      cmpmode_q, periodic_q, req_en_q, dbg_hold_q;
    req_kind_t req_q;
    logic [2:0] sel_q;
    logic      match_q, ovf_q;
    logic      wdata_unused;

    assign wdata_unused = ^{wdata[31:16], wdata[13:10], wdata[6]};

    // Purpose: store the writable mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpmode_q  <= 1'b0;
            periodic_q <= 1'b0;
            req_en_q   <= 1'b0;
            dbg_hold_q <= 1'b0;
            req_q      <= REQ_NONE;
            sel_q      <= '0;
        end else if (wr) begin
            cmpmode_q  <= wdata[B_CMPMODE];
            periodic_q <= wdata[B_PERIODIC];
            req_en_q   <= wdata[B_REQ_EN];
            dbg_hold_q <= wdata[B_DBG_HOLD];
            req_q      <= req_kind_t'(wdata[B_REQ_LO +: 2]);
            sel_q      <= wdata[2:0];
        end
    end

    // Purpose: flags set by events, cleared only by a written zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            match_q <= hit  || (match_q && !(wr && !wdata[B_MATCH]));
            ovf_q   <= wrap || (ovf_q   && !(wr && !wdata[B_OVF]));
        end
    end

    // Purpose: assemble readback and the request outputs.
    always_comb begin
        rdata = '0;
        rdata[B_MATCH]          = match_q;
        rdata[B_OVF]            = ovf_q;
        rdata[B_CMPMODE]        = cmpmode_q;
        rdata[B_PERIODIC]       = periodic_q;
        rdata[B_REQ_EN]         = req_en_q;
        rdata[B_REQ_LO +: 2]    = req_q;
        rdata[B_DBG_HOLD]       = dbg_hold_q;
        rdata[2:0]              = sel_q;
        periodic   = periodic_q;
        sel        = sel_q;
        match_flag = match_q;
        irq        = match_q && req_en_q && (req_q == REQ_IRQ);
        dma_req    = match_q && req_en_q && (req_q == REQ_DMA);
    end

    // R8: a hardware match event always leaves the flag set
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> match_q);

    // R8: writing one to a set flag keeps it
    assert_w1_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_MATCH] && match_q) |=> match_q);

    // R7: a wrap event sets the overflow flag
    assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);

endmodule

// File: rtl/cmt_channel.sv
// Top: one compare-match timer channel. Decodes the register port,
// holds the compare register and ties prescaler, write synchroniser,
// counter core and control register together. Assumes CNT_W <= 32 and
// byte addresses with word index in reg_addr[3:2].
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        start_i,
    input  logic        tick_i,
    output logic        irq_o,
    output logic        dma_req_o
);
    word_sel_t        word;
    logic             wr_ctrl, wr_count, wr_cmp;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] ctrl_rd;
    logic             cnt_en, load, hit, wrap, periodic, match_flag;
    logic [CNT_W-1:0] load_val;
    logic [2:0]       sel;
    logic             addr_lsb_unused;

    assign addr_lsb_unused = ^reg_addr[WORD_LSB-1:0];

    // Purpose: decode the word select and the per-register write strobes.
    always_comb begin
        word     = word_sel_t'(reg_addr[WORD_LSB +: 2]);
        wr_ctrl  = reg_we && (word == W_CTRL);
        wr_count = reg_we && (word == W_COUNT);
        wr_cmp   = reg_we && (word == W_COMPARE);
    end

    // Purpose: compare register, written directly from the port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (wr_cmp)
            cmp_q <= reg_wdata[CNT_W-1:0];
    end

    // Purpose: read multiplexer.
    always_comb begin
        case (word)
            W_CTRL:    reg_rdata = ctrl_rd;
            W_COUNT:   reg_rdata = 32'(count);
            W_COMPARE: reg_rdata = 32'(cmp_q);
            default:   reg_rdata = '0;
        endcase
    end

    cmt_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .sel     (sel),
        .restart (wr_ctrl),
        .cnt_en  (cnt_en)
    );

    cmt_cnt_sync #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_count),
        .wdata    (reg_wdata[CNT_W-1:0]),
        .cnt_en   (cnt_en),
        .load     (load),
        .load_val (load_val)
    );

    cmt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .run      (start_i),
        .periodic (periodic),
        .cmp      (cmp_q),
        .load     (load),
        .load_val (load_val),
        .count    (count),
        .hit      (hit),
        .wrap     (wrap)
    );

    cmt_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_ctrl),
        .wdata      (reg_wdata),
        .hit        (hit),
        .wrap       (wrap),
        .rdata      (ctrl_rd),
        .periodic   (periodic),
        .sel        (sel),
        .match_flag (match_flag),
        .irq        (irq_o),
        .dma_req    (dma_req_o)
    );

    // R5: the match flag only rises after a count tick
    assert_flag_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(cnt_en));

    // R10: interrupt and DMA request are never both active
    assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && dma_req_o));

endmodule

// File: tb/cmt_channel_tb.sv
`timescale 1ns/1ps
module cmt_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        irq_o, dma_req_o;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cmt_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_i(start_i),
        .tick_i(tick_i), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_we = 1'b0; tick_i = 1'b0; start_i = 1'b0;
        steps(3);
        rst_n = 1'b1;
        step();
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [2:0]  sels [4];
        int          ratios [4];
        sels[0] = 3'd7; sels[1] = 3'd4; sels[2] = 3'd5; sels[3] = 3'd6;
        ratios[0] = 1;  ratios[1] = 8;  ratios[2] = 32; ratios[3] = 128;

        // R1: reset state and map
        do_reset();
        rd(4'h0, v); chk("R1 ctrl reset", v, 32'h0);
        rd(4'h4, v); chk("R1 count reset", v, 32'h0);
        rd(4'h8, v); chk("R1 compare reset", v, 32'h0);
        chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
        chk("R1 dma reset", {31'b0, dma_req_o}, 32'h0);
        wr(4'h8, 32'h1234_5678);
        rd(4'h8, v); chk("R1 compare rw", v, 32'h1234_5678);
        rd(4'hC, v); chk("R1 unused word", v, 32'h0);

        // R2: field storage
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R2 ctrl all ones", v, 32'h0000_03BF);
        wr(4'h0, 32'h0000_0000);
        rd(4'h0, v); chk("R2 ctrl zero", v, 32'h0);

        // R3: divide ratios
        for (int s = 0; s < 4; s++) begin
            do_reset();
            wr(4'h8, 32'hFFFF_FFFF);
            wr(4'h0, {29'b0, sels[s]});
            tick_i = 1'b1; start_i = 1'b1;
            steps(ratios[s] - 1);
            rd(4'h4, v); chk($sformatf("R3 sel%0d before", sels[s]), v, 32'd0);
            steps(2 * ratios[s] + 1);
            rd(4'h4, v); chk($sformatf("R3 sel%0d after", sels[s]), v, 32'd3);
            tick_i = 1'b0; start_i = 1'b0;
        end
        // R3: dead select codes
        for (int s = 0; s < 4; s++) begin
            do_reset();
            wr(4'h0, 32'(s));
            tick_i = 1'b1; start_i = 1'b1;
            steps(20);
            rd(4'h4, v); chk($sformatf("R3 dead sel%0d", s), v, 32'd0);
            tick_i = 1'b0; start_i = 1'b0;
        end

        // R4: hold while stopped
        do_reset();
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h0, 32'h7);
        tick_i = 1'b1;
        steps(10);
        rd(4'h4, v); chk("R4 stopped from reset", v, 32'd0);
        start_i = 1'b1; steps(5);
        rd(4'h4, v); chk("R4 running", v, 32'd5);
        start_i = 1'b0; steps(5);
        rd(4'h4, v); chk("R4 held", v, 32'd5);
        tick_i = 1'b0;

        // R5: periodic sweep over compare values
        for (int c = 0; c < 6; c++) begin
            do_reset();
            wr(4'h0, 32'h107);
            wr(4'h8, 32'(c));
            tick_i = 1'b1; start_i = 1'b1;
            for (int k = 1; k <= 2 * (c + 1) + 1; k++) begin
                step();
                rd(4'h4, v);
                chk($sformatf("R5 cmp%0d k%0d count", c, k), v, 32'(k % (c + 1)));
                rd(4'h0, v);
                chk($sformatf("R5 cmp%0d k%0d flag", c, k), {31'b0, v[15]},
                    (k >= c + 1) ? 32'd1 : 32'd0);
            end
            tick_i = 1'b0; start_i = 1'b0;
        end

        // R6: free-running passes compare
        do_reset();
        wr(4'h0, 32'h7);
        wr(4'h8, 32'd3);
        tick_i = 1'b1; start_i = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            step();
            rd(4'h4, v); chk($sformatf("R6 k%0d count", k), v, 32'(k));
            rd(4'h0, v); chk($sformatf("R6 k%0d flag", k), {31'b0, v[15]},
                             (k >= 4) ? 32'd1 : 32'd0);
        end
        tick_i = 1'b0; start_i = 1'b0;

        // R7 + R9: overflow without match, counter loaded while stopped
        do_reset();
        wr(4'h0, 32'h7);
        wr(4'h8, 32'd5);
        wr(4'h4, 32'hFFFF_FFFE);
        tick_i = 1'b1;
        step();
        rd(4'h4, v); chk("R9 old value after one tick", v, 32'h0);
        step();
        rd(4'h4, v); chk("R9 landed while stopped", v, 32'hFFFF_FFFE);
        start_i = 1'b1;
        step();
        rd(4'h0, v); chk("R7 no ovf at all-ones", v, 32'h0000_0007);
        step();
        tick_i = 1'b0; start_i = 1'b0;
        rd(4'h4, v); chk("R7 wrapped to zero", v, 32'h0);
        rd(4'h0, v); chk("R7 ovf only", v, 32'h0000_4007);

        // R7: periodic with compare all-ones sets both
        do_reset();
        wr(4'h0, 32'h107);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h4, 32'hFFFF_FFFF);
        tick_i = 1'b1; steps(2);
        start_i = 1'b1; step();
        tick_i = 1'b0; start_i = 1'b0;
        rd(4'h4, v); chk("R7 periodic wrap count", v, 32'h0);
        rd(4'h0, v); chk("R7 both flags", v, 32'h0000_C107);

        // R8: write-zero-to-clear
        wr(4'h0, 32'h0000_C107);
        rd(4'h0, v); chk("R8 ones keep flags", v, 32'h0000_C107);
        wr(4'h0, 32'h0000_4107);
        rd(4'h0, v); chk("R8 clear match only", v, 32'h0000_4107);
        wr(4'h0, 32'h0000_0107);
        rd(4'h0, v); chk("R8 clear ovf", v, 32'h0000_0107);
        // R8: set wins over same-cycle clear
        do_reset();
        wr(4'h0, 32'h107);
        start_i = 1'b1;
        tick_i = 1'b1;
        wr(4'h0, 32'h107);
        tick_i = 1'b0; start_i = 1'b0;
        rd(4'h0, v); chk("R8 set wins", v, 32'h0000_8107);

        // R9: newer write restarts wait
        do_reset();
        wr(4'h0, 32'h7);
        wr(4'h4, 32'd50);
        tick_i = 1'b1; step(); tick_i = 1'b0;
        wr(4'h4, 32'd70);
        tick_i = 1'b1; step();
        rd(4'h4, v); chk("R9 restart pending", v, 32'd0);
        step(); tick_i = 1'b0;
        rd(4'h4, v); chk("R9 newest lands", v, 32'd70);
        // R9: latency under divide-by-8
        do_reset();
        wr(4'h0, 32'h4);
        wr(4'h4, 32'd9);
        tick_i = 1'b1;
        steps(15);
        rd(4'h4, v); chk("R9 div8 before", v, 32'd0);
        step(); tick_i = 1'b0;
        rd(4'h4, v); chk("R9 div8 landed", v, 32'd9);

        // R10: request decode
        do_reset();
        wr(4'h0, 32'h1A7);
        start_i = 1'b1; tick_i = 1'b1; step();
        start_i = 1'b0; tick_i = 1'b0;
        chk("R10 irq type2", {30'b0, irq_o, dma_req_o}, 32'b10);
        wr(4'h0, 32'h8197);
        chk("R10 dma type1", {30'b0, irq_o, dma_req_o}, 32'b01);
        wr(4'h0, 32'h8187);
        chk("R10 none type0", {30'b0, irq_o, dma_req_o}, 32'b00);
        wr(4'h0, 32'h81B7);
        chk("R10 none type3", {30'b0, irq_o, dma_req_o}, 32'b00);
        wr(4'h0, 32'h8127);
        chk("R10 enable off", {30'b0, irq_o, dma_req_o}, 32'b00);
        wr(4'h0, 32'h81A7);
        chk("R10 irq again", {30'b0, irq_o, dma_req_o}, 32'b10);
        wr(4'h0, 32'h01A7);
        chk("R10 cleared flag", {30'b0, irq_o, dma_req_o}, 32'b00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule